// File: doc/BRIEF.md
# Modulo 2^n−1 Parallel-Prefix Adder

This block adds two unsigned n-bit operands modulo 2^n−1, the one's-complement ring used in residue-number datapaths and checksum arithmetic. The operand width is a parameter (default 16). The adder has three stages. The first stage forms per-bit generate, propagate and half-sum signals. A cyclic prefix network then computes every carry. A final XOR stage produces the sum.

The end-around carry is built into the prefix network. Each carry combines all n generate/propagate pairs in rotated order, so the carry into bit 0 comes from the top of the ring without a wire from carry-out back to carry-in. This gives ceil(log2 n) prefix levels, with no increment stage and no combinational loop.

A parameter selects the output timing. The result can be presented combinationally, or through one output register that uses an asynchronous active-low reset. Zero may appear in either of its two encodings: all zeros or all ones.

Top module: `mod_eac_adder`

## Requirements
- R1: When the integer sum A+B is below 2^n, S equals A+B.
- R2: When A+B is 2^n or more, S equals (A+B+1) mod 2^n.
- R3: Zero keeps the encoding that the arithmetic produces:
  - A+B = 2^n−1 gives S all ones.
  - A = B = 0 gives S all zeros.
  - A = B = all ones gives S all ones.
- R4: An all-ones operand acts as zero: with B all ones and A nonzero, S equals A.
- R5: Every result is congruent to A+B modulo 2^n−1.
- R6: The output timing follows the REG_OUT parameter:
  - With REG_OUT=1, S shows the result for the operands sampled at the previous rising clock edge.
  - With REG_OUT=0, S follows the operands in the same cycle.
- R7: With REG_OUT=1, S is all zeros while rst_n is low, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the surrounding logic |
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| s_o | output | N | Sum modulo 2^n−1 |

## Verification
The assertions check the following on every cycle, against the operands' integer sum:
- the split between the non-wrapping and wrapping cases;
- the all-ones form of zero;
- the all-ones-operand identity;
- the one-cycle latency of the registered output.

Only the bench's scenarios can show two things: that the whole 8-bit operand space is congruent with the modular reference, which comes from an exhaustive sweep on a combinational instance, and that the output is held at zero while reset is asserted. A 16-bit registered instance is driven with corner vectors and random vectors and compared against a queue-based model on every clock.

// File: rtl/mod_add_pkg.sv
package mod_add_pkg;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Prefix association: 'hi' covers the more significant span.
  function automatic gp_t gp_combine(gp_t hi, gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

endpackage

// File: rtl/madd_preproc.sv
module madd_preproc #(
  parameter int N = 16
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] gen_o,
  output logic [N-1:0] prop_o,
  output logic [N-1:0] half_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      gen_o[i]  = a_i[i] & b_i[i];
      prop_o[i] = a_i[i] | b_i[i];
      half_o[i] = a_i[i] ^ b_i[i];
    end
  end

endmodule

// File: rtl/madd_cyclic_tree.sv
module madd_cyclic_tree
  import mod_add_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  output logic [N-1:0] carry_o
);

  // Each level doubles the span of every node, wrapping around the ring.
  // Spans wider than N stay correct because the operator is idempotent
  // on a full ring.
  localparam int LVLS = (N > 1) ? $clog2(N) : 1;

  gp_t node [0:LVLS][N-1:0];

  for (genvar i = 0; i < N; i++) begin : g_leaf
    always_comb begin
      node[0][i].g = gen_i[i];
      node[0][i].p = prop_i[i];
    end
  end

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    localparam int SHIFT = (1 << l) % N;
    for (genvar i = 0; i < N; i++) begin : g_col
      localparam int J = (i + N - SHIFT) % N;
      always_comb begin
        node[l+1][i] = gp_combine(node[l][i], node[l][J]);
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_out
    always_comb begin
      carry_o[i] = node[LVLS][i].g;
    end
  end

endmodule

// File: rtl/madd_postproc.sv
module madd_postproc #(
  parameter int N = 16
) (
  input  logic [N-1:0] half_i,
  input  logic [N-1:0] carry_i,
  output logic [N-1:0] sum_o
);

  // The carry into bit 0 is the ring carry of the top bit.
  for (genvar i = 0; i < N; i++) begin : g_bit
    localparam int K = (i + N - 1) % N;
    always_comb begin
      sum_o[i] = half_i[i] ^ carry_i[K];
    end
  end

endmodule

// File: rtl/mod_eac_adder.sv
module mod_eac_adder #(
  parameter int N       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] s_o
);

  localparam logic [N-1:0] ALL1 = {N{1'b1}};
  localparam logic [N-1:0] ONE  = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] gen_w;
  logic [N-1:0] prop_w;
  logic [N-1:0] half_w;
  logic [N-1:0] carry_w;
  logic [N-1:0] sum_w;

  madd_preproc #(.N(N)) u_pre (
    .a_i    (a_i),
    .b_i    (b_i),
    .gen_o  (gen_w),
    .prop_o (prop_w),
    .half_o (half_w)
  );

  madd_cyclic_tree #(.N(N)) u_tree (
    .gen_i   (gen_w),
    .prop_i  (prop_w),
    .carry_o (carry_w)
  );

  madd_postproc #(.N(N)) u_post (
    .half_i  (half_w),
    .carry_i (carry_w),
    .sum_o   (sum_w)
  );

  // Integer sum of the operands, used only by the checks below.
  logic [N:0] wide_w;
  assign wide_w = {1'b0, a_i} + {1'b0, b_i};

  p_no_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_w[N] |-> (sum_w == wide_w[N-1:0]));

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wide_w[N] |-> (sum_w == (wide_w[N-1:0] + ONE)));

  p_zero_enc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_w == {1'b0, ALL1}) |-> (sum_w == ALL1));

  p_ones_operand_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((b_i == ALL1) && (a_i != '0)) |-> (sum_w == a_i));

  if (REG_OUT) begin : g_reg
    logic [N-1:0] s_d;
    logic [N-1:0] s_q;
    logic         primed_q;
    logic [N-1:0] model_w;

    always_comb begin
      s_d = sum_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_q <= '0;
      end else begin
        s_q <= s_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        primed_q <= 1'b0;
      end else begin
        primed_q <= 1'b1;
      end
    end

    always_comb begin
      model_w = wide_w[N] ? (wide_w[N-1:0] + ONE) : wide_w[N-1:0];
    end

    assign s_o = s_q;

    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      primed_q |-> (s_o == $past(model_w)));
  end else begin : g_comb
    assign s_o = sum_w;
  end

endmodule

// File: tb/mod_eac_adder_tb_top.sv
module mod_eac_adder_tb_top;

  localparam int NW = 16;
  localparam int NS = 8;

  logic clk;
  logic rst_n;
  logic [NW-1:0] a16, b16, s16;
  logic [NS-1:0] a8, b8, s8;

  int checks;
  int failures;
  bit done;

  longint unsigned q_a[$];
  longint unsigned q_b[$];

  mod_eac_adder #(.N(NW), .REG_OUT(1'b1)) dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .a_i   (a16),
    .b_i   (b16),
    .s_o   (s16)
  );

  mod_eac_adder #(.N(NS), .REG_OUT(1'b0)) dut8_i (
    .clk   (clk),
    .rst_n (rst_n),
    .a_i   (a8),
    .b_i   (b8),
    .s_o   (s8)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic longint unsigned model(longint unsigned a, longint unsigned b, int n);
    longint unsigned lim = 64'd1 << n;
    longint unsigned t = a + b;
    return (t < lim) ? t : ((t + 1) % lim);
  endfunction

  function automatic string tag(longint unsigned a, longint unsigned b, int n);
    longint unsigned lim = 64'd1 << n;
    if (a == 0 && b == 0) return "R3";
    if (a == lim - 1 && b == lim - 1) return "R3";
    if (a + b == lim - 1) return "R3";
    if (b == lim - 1 && a != 0) return "R4";
    if (a + b < lim) return "R1";
    return "R2";
  endfunction

  task automatic chk(string req, longint unsigned act, longint unsigned exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_result(longint unsigned a, longint unsigned b, longint unsigned s,
                              int n, string lat);
    longint unsigned m = (64'd1 << n) - 1;
    chk({tag(a, b, n), lat}, s, model(a, b, n), $sformatf("n=%0d a=%0h b=%0h", n, a, b));
    chk({"R5", lat}, s % m, (a + b) % m, $sformatf("residue n=%0d a=%0h b=%0h", n, a, b));
  endtask

  // One cycle: apply operands at a falling edge, check the combinational
  // instance, then check the registered instance one clock later.
  task automatic step(logic [NS-1:0] x8, logic [NS-1:0] y8,
                      logic [NW-1:0] x16, logic [NW-1:0] y16);
    a8 = x8;
    b8 = y8;
    a16 = x16;
    b16 = y16;
    q_a.push_back(longint'(x16));
    q_b.push_back(longint'(y16));
    #1;
    check_result(longint'(a8), longint'(b8), longint'(s8), NS, "/R6 comb");
    @(negedge clk);
    check_result(q_a.pop_front(), q_b.pop_front(), longint'(s16), NW, "/R6 reg");
  endtask

  initial begin
    checks = 0;
    failures = 0;
    done = 1'b0;
    rst_n = 1'b0;
    a8 = '0;
    b8 = '0;
    a16 = '0;
    b16 = '0;

    // R7: the registered output stays zero during reset, even with live operands.
    repeat (2) @(negedge clk);
    chk("R7", longint'(s16), 0, "reset with zero operands");
    a16 = 16'h1234;
    b16 = 16'hF0F0;
    @(negedge clk);
    chk("R7", longint'(s16), 0, "reset with nonzero operands");
    @(negedge clk);
    rst_n = 1'b1;

    // Directed corner vectors (R1..R4), on both widths.
    step(8'h00, 8'h00, 16'h0000, 16'h0000);
    step(8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF);
    step(8'h0F, 8'hF0, 16'h00FF, 16'hFF00);
    step(8'h00, 8'hFF, 16'h0000, 16'hFFFF);
    step(8'h01, 8'hFF, 16'h0001, 16'hFFFF);
    step(8'h5A, 8'hFF, 16'hBEEF, 16'hFFFF);
    step(8'h80, 8'h80, 16'h8000, 16'h8000);
    step(8'h12, 8'h34, 16'h1234, 16'h4321);
    step(8'hFE, 8'h02, 16'hFFFE, 16'h0002);
    step(8'h7F, 8'h80, 16'h7FFF, 16'h8000);

    // Exhaustive 8-bit sweep; random 16-bit operands in parallel.
    for (int i = 0; i < 65536; i++) begin
      step(i[15:8], i[7:0], NW'($urandom), NW'($urandom));
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R6 actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule